// File: doc/BRIEF.md
# LCD Horizontal Line Timing Generator

This block produces the timing of one display line for an LCD panel interface. Time is counted in periods of the panel shift clock. That clock is not generated here: the system clock domain supplies a one-cycle `lsclk_en` strobe for each shift-clock period, and every counter moves only on that strobe.

A 32-bit configuration word sets three values:
- the width of the horizontal sync pulse,
- the gap between the end of the visible part of a line and the sync pulse,
- the gap between the end of the sync pulse and the start of the next visible part.

A mode input chooses between a TFT panel and a colour STN panel. In TFT mode the visible part is framed by an output-enable strobe. In STN mode it is framed by the first and last data clock, and output-enable stays low.

While `en` is high, the generator repeats the same sequence for every line: visible data, pre-sync gap, sync pulse, post-sync gap. A one-clock `line_start` pulse marks the start of each visible phase, so that vertical timing and pixel-fetch logic can track lines. The configuration word, the line length and the mode are captured at each line start, so a write in the middle of a line changes only the lines that follow.

Top module: `lcd_htim`

## Requirements
- R1: After reset, `cfg_rdata` reads 32'h0400_0000, which gives sync width field 1 and both wait fields 0. `data_valid`, `oe` and `line_start` are low, and `hsync` is at its inactive level.
- R2: A write stores bits [31:26] as the sync width field, bits [15:8] as the pre-sync wait and bits [7:0] as the post-sync wait. Bits [25:16] always read as zero, whatever value was written to them.
- R3: The visible phase keeps `data_valid` high for `line_len` shift-clock periods. In TFT mode (`mode_cstn`=0), `oe` is high exactly when `data_valid` is high.
- R4: The pre-sync gap, with `data_valid`, `oe` and sync all inactive, lasts (pre-sync wait + 1) periods.
- R5: The sync pulse lasts (sync width + 1) periods and never overlaps the visible phase.
- R6: In TFT mode, the post-sync gap from the end of sync to the next `oe` lasts (post-sync wait + 3) periods.
- R7: In STN mode (`mode_cstn`=1), the post-sync gap lasts (post-sync wait + 2) periods, and `oe` stays low.
- R8: `line_start` is high for exactly one system clock at the start of each visible phase, and is low at all other times.
- R9: A configuration write made during a line leaves the timing of that line unchanged. The new values apply from the next line start.
- R10: With `hs_act_low`=0 the sync pulse drives `hsync` high. With `hs_act_low`=1 it drives `hsync` low, and `hsync` idles high.
- R11: No output changes on a system clock that carries no `lsclk_en` strobe while `en` stays high.
- R12: When `en` is low, the generator returns to idle on the next clock. Raising `en` again starts a new line with `line_start` on the next strobe.
- R13: A `line_len` of zero gives a visible phase of one period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle |
| lsclk_en | input | 1 | One-cycle strobe per shift-clock period |
| mode_cstn | input | 1 | 0 = TFT timing, 1 = colour STN timing |
| hs_act_low | input | 1 | 1 = sync pulse drives hsync low |
| line_len | input | LEN_W | Visible shift-clock periods per line |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback, reserved bits zero |
| hsync | output | 1 | Horizontal sync |
| oe | output | 1 | TFT output-enable strobe |
| data_valid | output | 1 | Visible data window |
| line_start | output | 1 | One-clock marker at start of visible phase |

## Verification
The hardest case to reach is a configuration write that lands inside the visible phase of a running line. If the new values were captured at the wrong moment, the current line would be cut short or stretched. The bench waits until it sees `line_start` at the port, then writes a new word and a new line length. It expects the old timing for the line in progress and the new timing for the next line. Other runs thin the strobe to one in every two or three clocks, so that any counter moving on a clock without a strobe shows up as wrong phase lengths or as output changes between strobes.

// File: rtl/lcd_htim_pkg.sv
package lcd_htim_pkg;

   // Position of each field within the configuration word
   localparam int SW_HI   = 31;
   localparam int SW_LO   = 26;
   localparam int RSV_HI  = 25;
   localparam int RSV_LO  = 16;
   localparam int PRE_HI  = 15;
   localparam int PRE_LO  = 8;
   localparam int POST_HI = 7;
   localparam int POST_LO = 0;

   localparam logic [31:0] CFG_RESET = 32'h0400_0000;

   // Extra periods added to the post-sync field, by panel type
   localparam int POST_ADD_TFT  = 3;
   localparam int POST_ADD_CSTN = 2;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ACT  = 3'd1,
      PH_PRE  = 3'd2,
      PH_SYNC = 3'd3,
      PH_POST = 3'd4
   } phase_t;

   typedef struct packed {
      logic [SW_HI-SW_LO:0]     sw;
      logic [PRE_HI-PRE_LO:0]   pre;
      logic [POST_HI-POST_LO:0] post;
   } hfield_t;

   localparam hfield_t FLD_RESET = '{sw: CFG_RESET[SW_HI:SW_LO],
                                     pre: CFG_RESET[PRE_HI:PRE_LO],
                                     post: CFG_RESET[POST_HI:POST_LO]};

endpackage

// File: rtl/lcd_htim_cfg.sv
module lcd_htim_cfg
   import lcd_htim_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output hfield_t     fld
);

   logic [31:0] word_q;
   logic [31:0] word_d;
   logic        unused_rsv_bits;

   assign unused_rsv_bits = ^wdata[RSV_HI:RSV_LO];

   // Per-bit next value: reserved bits are constant zero
   for (genvar b = 0; b < 32; b++) begin : g_bit
      if (b >= RSV_LO && b <= RSV_HI) begin : g_rsv
         assign word_d[b] = 1'b0;
      end else begin : g_rw
         assign word_d[b] = wr ? wdata[b] : word_q[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= CFG_RESET;
      else        word_q <= word_d;
   end

   assign rdata    = word_q;
   assign fld.sw   = word_q[SW_HI:SW_LO];
   assign fld.pre  = word_q[PRE_HI:PRE_LO];
   assign fld.post = word_q[POST_HI:POST_LO];

endmodule

// File: rtl/lcd_htim_seq.sv
module lcd_htim_seq
   import lcd_htim_pkg::*;
#(
   parameter int LEN_W = 12,
   parameter int CNT_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             mode_cstn,
   input  logic [LEN_W-1:0] line_len,
   input  hfield_t          fld,
   output phase_t           ph,
   output logic             sh_cstn,
   output logic             line_start
);

   logic [CNT_W-1:0] cnt, cnt_n;
   logic [CNT_W-1:0] len_ld;
   logic [CNT_W-1:0] post_ld;
   hfield_t          sh, sh_n;
   phase_t           ph_n;
   logic             cstn_n;
   logic             ls_n;
   logic             done;

   // Period count minus one for each phase
   assign len_ld  = (line_len == '0) ? '0 : (CNT_W'(line_len) - CNT_W'(1));
   assign post_ld = CNT_W'(sh.post) +
                    (sh_cstn ? CNT_W'(POST_ADD_CSTN - 1) : CNT_W'(POST_ADD_TFT - 1));
   assign done    = (cnt == '0);

   always_comb begin
      ph_n   = ph;
      cnt_n  = cnt;
      sh_n   = sh;
      cstn_n = sh_cstn;
      ls_n   = 1'b0;
      if (!en) begin
         ph_n  = PH_IDLE;
         cnt_n = '0;
      end else if (tick) begin
         unique case (ph)
            PH_IDLE: begin
               ph_n   = PH_ACT;
               cnt_n  = len_ld;
               sh_n   = fld;
               cstn_n = mode_cstn;
               ls_n   = 1'b1;
            end
            PH_ACT: begin
               if (done) begin
                  ph_n  = PH_PRE;
                  cnt_n = CNT_W'(sh.pre);
               end else begin
                  cnt_n = cnt - CNT_W'(1);
               end
            end
            PH_PRE: begin
               if (done) begin
                  ph_n  = PH_SYNC;
                  cnt_n = CNT_W'(sh.sw);
               end else begin
                  cnt_n = cnt - CNT_W'(1);
               end
            end
            PH_SYNC: begin
               if (done) begin
                  ph_n  = PH_POST;
                  cnt_n = post_ld;
               end else begin
                  cnt_n = cnt - CNT_W'(1);
               end
            end
            PH_POST: begin
               if (done) begin
                  ph_n   = PH_ACT;
                  cnt_n  = len_ld;
                  sh_n   = fld;
                  cstn_n = mode_cstn;
                  ls_n   = 1'b1;
               end else begin
                  cnt_n = cnt - CNT_W'(1);
               end
            end
            default: begin
               ph_n  = PH_IDLE;
               cnt_n = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph         <= PH_IDLE;
         cnt        <= '0;
         sh         <= FLD_RESET;
         sh_cstn    <= 1'b0;
         line_start <= 1'b0;
      end else begin
         ph         <= ph_n;
         cnt        <= cnt_n;
         sh         <= sh_n;
         sh_cstn    <= cstn_n;
         line_start <= ls_n;
      end
   end

endmodule

// File: rtl/lcd_htim_drv.sv
module lcd_htim_drv
   import lcd_htim_pkg::*;
(
   input  phase_t ph,
   input  logic   sh_cstn,
   input  logic   hs_act_low,
   output logic   hsync,
   output logic   oe,
   output logic   data_valid
);

   logic vis;

   assign vis        = (ph == PH_ACT);
   assign data_valid = vis;
   assign oe         = vis & ~sh_cstn;
   assign hsync      = (ph == PH_SYNC) ^ hs_act_low;

endmodule

// File: rtl/lcd_htim.sv
module lcd_htim
   import lcd_htim_pkg::*;
#(
   parameter int LEN_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             lsclk_en,
   input  logic             mode_cstn,
   input  logic             hs_act_low,
   input  logic [LEN_W-1:0] line_len,
   input  logic             cfg_wr,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   output logic             hsync,
   output logic             oe,
   output logic             data_valid,
   output logic             line_start
);

   // Counter must hold the largest post-sync load (255 + 2)
   localparam int MIN_CNT = 10;
   localparam int CNT_W   = (LEN_W > MIN_CNT) ? LEN_W : MIN_CNT;

   if (LEN_W < 2 || LEN_W > 16) begin : g_bad_len_w
      $error("lcd_htim: LEN_W must lie in 2..16");
   end

   hfield_t fld;
   phase_t  ph;
   logic    sh_cstn;

   lcd_htim_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .fld   (fld)
   );

   lcd_htim_seq #(
      .LEN_W (LEN_W),
      .CNT_W (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .tick       (lsclk_en),
      .mode_cstn  (mode_cstn),
      .line_len   (line_len),
      .fld        (fld),
      .ph         (ph),
      .sh_cstn    (sh_cstn),
      .line_start (line_start)
   );

   lcd_htim_drv u_drv (
      .ph         (ph),
      .sh_cstn    (sh_cstn),
      .hs_act_low (hs_act_low),
      .hsync      (hsync),
      .oe         (oe),
      .data_valid (data_valid)
   );

endmodule

// File: rtl/lcd_htim_chk.sv
module lcd_htim_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        en,
   input logic        lsclk_en,
   input logic        hs_act_low,
   input logic        cfg_wr,
   input logic [31:0] cfg_wdata,
   input logic [31:0] cfg_rdata,
   input logic        hsync,
   input logic        oe,
   input logic        data_valid,
   input logic        line_start
);

   assert_wr_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (cfg_rdata == ($past(cfg_wdata) & 32'hFC00_FFFF)));

   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[25:16] == 10'd0);

   assert_oe_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> data_valid);

   assert_no_sync_in_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (hsync == hs_act_low));

   assert_start_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> !line_start);

   assert_start_in_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |-> data_valid);

   assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!lsclk_en && en) |=> (!en || ($stable(data_valid) && $stable(oe) && !line_start)));

   assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!data_valid && !oe && !line_start));

endmodule

bind lcd_htim lcd_htim_chk u_chk (.*);

// File: tb/lcd_htim_tb.sv
module lcd_htim_tb;

   localparam int LEN_W = 12;
   localparam int K_GAP = 0;
   localparam int K_ACT = 1;
   localparam int K_SYN = 2;
   localparam int K_BAD = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic             lsclk_en = 1'b0;
   logic             mode_cstn = 1'b0;
   logic             hs_act_low = 1'b0;
   logic [LEN_W-1:0] line_len = '0;
   logic             cfg_wr = 1'b0;
   logic [31:0]      cfg_wdata = '0;
   logic [31:0]      cfg_rdata;
   logic             hsync, oe, data_valid, line_start;

   always #4 clk = ~clk;

   lcd_htim #(.LEN_W(LEN_W)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .lsclk_en   (lsclk_en),
      .mode_cstn  (mode_cstn),
      .hs_act_low (hs_act_low),
      .line_len   (line_len),
      .cfg_wr     (cfg_wr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .hsync      (hsync),
      .oe         (oe),
      .data_valid (data_valid),
      .line_start (line_start)
   );

   typedef struct {
      int    kind;
      int    len;
      string tag;
   } seg_t;

   seg_t expq[$];
   int   n_chk = 0;
   int   n_bad = 0;
   int   tick_div = 1;
   int   div_cnt = 0;

   // Strobe generator: one strobe every tick_div clocks
   initial begin
      forever begin
         @(negedge clk);
         if (div_cnt >= tick_div - 1) begin
            lsclk_en = 1'b1;
            div_cnt  = 0;
         end else begin
            lsclk_en = 1'b0;
            div_cnt  = div_cnt + 1;
         end
      end
   end

   task automatic check(input string req, input int got, input int exp, input string what);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   // Monitor: folds strobe samples into segments and pops the queue
   int    cur_kind = 0;
   int    cur_len  = 0;
   bit    trk      = 1'b0;
   bit    seg_new  = 1'b0;
   bit    oe_bad   = 1'b0;
   logic  p_dv, p_oe, p_hs;

   always @(posedge clk) begin
      int   k;
      seg_t e;
      #1;
      k = data_valid ? ((hsync ^ hs_act_low) ? K_BAD : K_ACT)
                     : ((hsync ^ hs_act_low) ? K_SYN : K_GAP);
      if (rst_n && en) begin
         if (lsclk_en) begin
            if (trk) begin
               if (k != cur_kind) begin
                  e = expq.pop_front();
                  check(e.tag, cur_kind, e.kind, "segment kind");
                  check(e.tag, cur_len, e.len, "segment length");
                  check(e.tag, int'(oe_bad), 0, "oe mismatch inside segment");
                  if (expq.size() == 0) trk = 1'b0;
                  cur_kind = k;
                  cur_len  = 1;
                  seg_new  = 1'b1;
                  oe_bad   = 1'b0;
               end else begin
                  cur_len = cur_len + 1;
                  seg_new = 1'b0;
               end
            end else if (line_start && expq.size() > 0) begin
               trk      = 1'b1;
               cur_kind = k;
               cur_len  = 1;
               seg_new  = 1'b1;
               oe_bad   = 1'b0;
            end
            if (trk) begin
               check("R8", int'(line_start), int'(k == K_ACT && seg_new), "line_start at strobe");
               if (oe != ((k == K_ACT) && !mode_cstn)) oe_bad = 1'b1;
            end
         end else if (trk) begin
            check("R11", int'({data_valid, oe, hsync}), int'({p_dv, p_oe, p_hs}),
                  "outputs moved without strobe");
            check("R8", int'(line_start), 0, "line_start without strobe");
         end
      end
      p_dv = data_valid;
      p_oe = oe;
      p_hs = hsync;
   end

   function automatic logic [31:0] mk_cfg(input int wd, input int w1, input int w2);
      return {wd[5:0], 10'd0, w1[7:0], w2[7:0]};
   endfunction

   task automatic wr_cfg(input logic [31:0] d);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr    = 1'b0;
   endtask

   task automatic push(input int kind, input int len, input string tag);
      seg_t s;
      s.kind = kind;
      s.len  = len;
      s.tag  = tag;
      expq.push_back(s);
   endtask

   task automatic push_line(input bit cstn, input int wd, input int w1, input int w2,
                            input int len, input string act_tag, input string syn_tag);
      push(K_ACT, (len == 0) ? 1 : len, act_tag);
      push(K_GAP, w1 + 1, "R4");
      push(K_SYN, wd + 1, syn_tag);
      push(K_GAP, cstn ? (w2 + 2) : (w2 + 3), cstn ? "R7" : "R6");
   endtask

   task automatic drain_and_stop();
      while (expq.size() != 0) @(posedge clk);
      @(negedge clk);
      en = 1'b0;
      @(posedge clk);
      #1;
      check("R12", int'({data_valid, oe, line_start}), 0, "idle outputs after disable");
      check("R10", int'(hsync), int'(hs_act_low), "hsync idle level");
      repeat (4) @(posedge clk);
   endtask

   task automatic run(input bit cstn, input bit pol, input int div, input int wd,
                      input int w1, input int w2, input int len, input int nl,
                      input string act_tag, input string syn_tag);
      @(negedge clk);
      mode_cstn  = cstn;
      hs_act_low = pol;
      tick_div   = div;
      line_len   = LEN_W'(len);
      wr_cfg(mk_cfg(wd, w1, w2));
      for (int i = 0; i < nl; i++) push_line(cstn, wd, w1, w2, len, act_tag, syn_tag);
      @(negedge clk);
      en = 1'b1;
      drain_and_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: state during and after reset
      repeat (3) @(posedge clk);
      #1;
      check("R1", int'(cfg_rdata), 32'h0400_0000, "config reset value");
      check("R1", int'({data_valid, oe, line_start, hsync}), 0, "outputs in reset");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check("R1", int'(cfg_rdata), 32'h0400_0000, "config after reset release");

      // R2: reserved bits masked, fields placed
      wr_cfg(32'hFFFF_FFFF);
      #1;
      check("R2", int'(cfg_rdata), 32'hFC00_FFFF, "all-ones write readback");
      wr_cfg(32'h1E5A_3C7D);
      #1;
      check("R2", int'(cfg_rdata), 32'h1C00_3C7D, "mixed write readback");

      // R3 R4 R5 R6: TFT at reset field values, strobe every clock
      run(1'b0, 1'b0, 1, 1, 0, 0, 4, 3, "R3", "R5");
      // R11: sparse strobe, TFT
      run(1'b0, 1'b0, 3, 5, 7, 2, 10, 2, "R11", "R5");
      // R7: STN timing
      run(1'b1, 1'b0, 2, 3, 1, 4, 6, 3, "R7", "R5");
      // R10: inverted sync
      run(1'b0, 1'b1, 1, 2, 3, 1, 5, 2, "R3", "R10");
      // R13: zero line length
      run(1'b0, 1'b0, 1, 0, 2, 0, 0, 2, "R13", "R5");

      // R9: write during the visible phase of a line
      @(negedge clk);
      mode_cstn  = 1'b0;
      hs_act_low = 1'b0;
      tick_div   = 1;
      line_len   = LEN_W'(12);
      wr_cfg(mk_cfg(2, 1, 1));
      push_line(1'b0, 2, 1, 1, 12, "R9", "R9");
      push_line(1'b0, 4, 3, 5, 7, "R9", "R9");
      @(negedge clk);
      en = 1'b1;
      do begin
         @(posedge clk);
         #1;
      end while (!line_start);
      @(negedge clk);
      line_len = LEN_W'(7);
      wr_cfg(mk_cfg(4, 3, 5));
      drain_and_stop();

      // R12: restart after disable starts with a line start
      @(negedge clk);
      en = 1'b1;
      @(posedge clk);
      #1;
      check("R12", int'(line_start), 1, "line_start after re-enable");
      @(negedge clk);
      en = 1'b0;
      repeat (3) @(posedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule